// File: doc/BRIEF.md
# Packet-Oriented Isochronous Byte Port

This block sits between an external byte-wide device and a link layer that moves fixed-length isochronous packets. It runs entirely on the external port clock. A shared byte FIFO is used in one direction at a time. In the transmit direction the external side pushes bytes under a ready/enable handshake. Each completed packet of the programmed length is released to the link side as a valid/ready byte stream with an end marker. In the receive direction the link side deposits bytes. Once a whole packet is stored, the external side is told through the ready line and pulls the packet out byte by byte with its enable.

Several behaviours work on packet boundaries rather than on bytes. After each received packet is drained, ready drops for a cycle. A request to turn the port around to receive waits while a complete transmit packet is still stored. A bus-reset event stops the external side only once the packet being written is complete. The block also latches the cycle-timer value on a falling edge of the timestamp trigger in transmit, and forwards a timestamp-match indication in receive. A per-packet CRC-error flag from the link is carried alongside the receive readout.

Top module: `iso_fifo_port`

## Requirements
- R1: After reset the port is in receive mode with `ready`, `lk_tx_valid`, `dout_vld`, `crc_err` and `ts_match_out` all low.
- R2: In transmit mode (`dir_rx`=0), `ready` is high while at least two byte slots are free and low when one or none is free. A byte presented with `byte_en` while `ready` is low is still stored as long as the FIFO is not full. A byte presented when the FIFO is full is discarded.
- R3: In transmit mode `lk_tx_valid` stays low until `pkt_len` bytes of a packet have been written. The packet's bytes then leave on `lk_tx_data` in write order, one per clock with `lk_tx_ready` high, and `lk_tx_last` is high on the final byte only.
- R4: A change of `dir_rx` empties the FIFO and any partly written packet as the mode changes. Data stored in the old mode is never seen in the new mode.
- R5: While at least one complete transmit packet is stored, a change of `dir_rx` to 1 is deferred. Transmit continues until that packet has fully left, and the mode changes on the following clock.
- R6: A `bus_reset` pulse in transmit mode pulls `ready` low at the next packet boundary, immediately if no packet is partly written. From then on, written bytes are ignored until one complete packet has left on the link side, after which `ready` returns.
- R7: In receive mode `ready` is high exactly when at least one complete packet is stored. It is low for the one clock after the last byte of a packet is read, and high again afterwards if another packet remains.
- R8: In receive mode, each clock edge with `byte_en` high while a packet is available places the next stored byte on `dout`, with `dout_vld` high in the cycle after that edge. `dout_vld` is low in cycles after an edge that popped nothing.
- R9: A receive packet whose final link byte arrives with `lk_rx_crc_err` high has `crc_err` high alongside every one of its bytes on `dout`. Other packets read out with `crc_err` low.
- R10: In transmit mode, a clock edge that sees `ts_trig_n` low after it was high loads `cycle_timer` into `ts_value`. `ts_value` is otherwise unchanged, including on such edges in receive mode.
- R11: `ts_match_out` equals `ts_match_in` as sampled on the previous clock edge while in receive mode, and is low after an edge in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, all activity on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | Requested direction: 1 receive, 0 transmit |
| pkt_len | input | 16 | Packet length in bytes (0 treated as 1) |
| byte_en | input | 1 | External enable: write strobe in transmit, read strobe in receive |
| din | input | 8 | External write data |
| ready | output | 1 | Packet-level access permission to the external side |
| dout | output | 8 | External read data |
| dout_vld | output | 1 | `dout` holds a byte popped on the last edge |
| crc_err | output | 1 | CRC flag of the packet the current `dout` byte belongs to |
| bus_reset | input | 1 | One-clock bus-reset event pulse |
| lk_tx_valid | output | 1 | A released transmit byte is offered to the link |
| lk_tx_ready | input | 1 | Link accepts the offered byte |
| lk_tx_data | output | 8 | Transmit byte to the link |
| lk_tx_last | output | 1 | Offered byte is the final one of its packet |
| lk_rx_valid | input | 1 | Link delivers a receive byte |
| lk_rx_data | input | 8 | Receive byte from the link |
| lk_rx_crc_err | input | 1 | CRC error flag, sampled with the final byte of a packet |
| ts_trig_n | input | 1 | Timestamp trigger, active on its falling edge |
| cycle_timer | input | 32 | Current cycle-timer value |
| ts_value | output | 32 | Latched cycle-timer value |
| ts_match_in | input | 1 | Timestamp-match indication from the link side |
| ts_match_out | output | 1 | Registered timestamp-match indication |

## Verification
Write acceptance, packet release and bus-reset gating change the combinational `ready`, `lk_tx_valid` and `lk_tx_last` right after the edge that stored or popped a byte. The bench drives on the falling clock edge and reads these outputs at the next falling edge. Receive data, `dout_vld` and `crc_err` are registered, so the byte popped at an edge is read at the falling edge that follows it. The one-cycle gap in `ready` after a packet is drained is checked in that same half-cycle. A deferred direction change is checked one edge after the last transmit byte leaves, and the timestamp latch and match forward are each read one edge after the stimulus.

// File: rtl/iso_port_pkg.sv
package iso_port_pkg;
    typedef enum logic {
        MODE_TX = 1'b0,
        MODE_RX = 1'b1
    } port_mode_e;
endpackage

// File: rtl/iso_byte_ram.sv
module iso_byte_ram #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/iso_pkt_flags.sv
module iso_pkt_flags #(
    parameter int N  = 32,
    parameter int PW = $clog2(N)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic push,
    input  logic bit_in,
    input  logic pop,
    output logic head
);
    localparam logic [PW-1:0] LAST_C = PW'(N - 1);

    logic [N-1:0]  bits_d, bits_q;
    logic [PW-1:0] wp_d, wp_q, rp_d, rp_q;

    always_comb begin
        bits_d = bits_q;
        wp_d   = wp_q;
        rp_d   = rp_q;
        if (clear) begin
            wp_d = '0;
            rp_d = '0;
        end else begin
            if (push) begin
                bits_d[wp_q] = bit_in;
                wp_d = (wp_q == LAST_C) ? '0 : wp_q + 1'b1;
            end
            if (pop) rp_d = (rp_q == LAST_C) ? '0 : rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            wp_q   <= '0;
            rp_q   <= '0;
        end else begin
            bits_q <= bits_d;
            wp_q   <= wp_d;
            rp_q   <= rp_d;
        end
    end

    assign head = bits_q[rp_q];
endmodule

// File: rtl/iso_ts_unit.sv
module iso_ts_unit #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            is_tx,
    input  logic            trig_n,
    input  logic [TS_W-1:0] timer,
    input  logic            match_in,
    output logic [TS_W-1:0] stamp,
    output logic            match_out
);
    typedef struct packed {
        logic            prev;
        logic [TS_W-1:0] stamp;
        logic            match;
    } ts_st_t;

    ts_st_t d, q;

    always_comb begin
        d       = q;
        d.prev  = trig_n;
        d.match = !is_tx && match_in;
        if (is_tx && q.prev && !trig_n) d.stamp = timer;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prev  <= 1'b1;
            q.stamp <= '0;
            q.match <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign stamp     = q.stamp;
    assign match_out = q.match;

    // R10
    stamp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tx && $fell(trig_n)) |=> (stamp == $past(timer)));
endmodule

// File: rtl/iso_fifo_port.sv
module iso_fifo_port
    import iso_port_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LEN_W = 16,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_rx,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             byte_en,
    input  logic [7:0]       din,
    output logic             ready,
    output logic [7:0]       dout,
    output logic             dout_vld,
    output logic             crc_err,
    input  logic             bus_reset,
    output logic             lk_tx_valid,
    input  logic             lk_tx_ready,
    output logic [7:0]       lk_tx_data,
    output logic             lk_tx_last,
    input  logic             lk_rx_valid,
    input  logic [7:0]       lk_rx_data,
    input  logic             lk_rx_crc_err,
    input  logic             ts_trig_n,
    input  logic [TS_W-1:0]  cycle_timer,
    output logic [TS_W-1:0]  ts_value,
    input  logic             ts_match_in,
    output logic             ts_match_out
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_C  = CW'(DEPTH);
    localparam logic [CW-1:0] ROOM_C  = CW'(DEPTH - 2);
    localparam logic [CW-1:0] SLACK_C = CW'(DEPTH - 1);
    localparam logic [AW-1:0] PEND_C  = AW'(DEPTH - 1);

    typedef struct packed {
        port_mode_e      mode;
        logic [CW-1:0]   cnt;
        logic [AW-1:0]   wptr;
        logic [AW-1:0]   rptr;
        logic [LEN_W-1:0] wcnt;
        logic [LEN_W-1:0] rcnt;
        logic [CW-1:0]   pkts;
        logic            pend;
        logic            gate;
        logic            hold;
        logic [7:0]      dout;
        logic            dvld;
        logic            derr;
    } st_t;

    st_t d, q;

    logic [LEN_W-1:0] plen_m1;
    logic             is_tx, full, blocked, switch_req;
    logic             push, tx_pop, rx_pop, pop, w_last, r_last;
    logic [7:0]       push_data, rdata;
    logic             flag_head;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == PEND_C) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        plen_m1    = (pkt_len == '0) ? '0 : pkt_len - 1'b1;
        is_tx      = (q.mode == MODE_TX);
        full       = (q.cnt == FULL_C);
        blocked    = q.gate || (q.pend && q.wcnt == '0);
        switch_req = (dir_rx != q.mode) && !(is_tx && q.pkts != '0);
        push       = !switch_req && (is_tx ? (byte_en && !full && !blocked)
                                           : (lk_rx_valid && !full));
        push_data  = is_tx ? din : lk_rx_data;
        tx_pop     = is_tx && (q.pkts != '0) && lk_tx_ready;
        rx_pop     = !is_tx && !switch_req && byte_en && (q.pkts != '0) && !q.hold;
        pop        = tx_pop || rx_pop;
        w_last     = push && (q.wcnt == plen_m1);
        r_last     = pop && (q.rcnt == plen_m1);
    end

    always_comb begin
        d      = q;
        d.hold = 1'b0;
        d.dvld = 1'b0;
        d.derr = 1'b0;
        if (switch_req) begin
            d.mode = port_mode_e'(dir_rx);
            d.cnt  = '0;
            d.wptr = '0;
            d.rptr = '0;
            d.wcnt = '0;
            d.rcnt = '0;
            d.pkts = '0;
            d.pend = 1'b0;
            d.gate = 1'b0;
        end else begin
            if (push) begin
                d.wptr = ptr_inc(q.wptr);
                d.wcnt = w_last ? '0 : q.wcnt + 1'b1;
            end
            if (pop) begin
                d.rptr = ptr_inc(q.rptr);
                d.rcnt = r_last ? '0 : q.rcnt + 1'b1;
            end
            d.cnt  = q.cnt + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};
            d.pkts = q.pkts + {{(CW-1){1'b0}}, w_last} - {{(CW-1){1'b0}}, r_last};
            if (rx_pop) begin
                d.dout = rdata;
                d.dvld = 1'b1;
                d.derr = flag_head;
                d.hold = r_last;
            end
            if (is_tx) begin
                if (q.pend && q.wcnt == '0) begin
                    d.gate = 1'b1;
                    d.pend = 1'b0;
                end
                if (bus_reset) d.pend = 1'b1;
                if (q.gate && r_last) d.gate = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= MODE_RX;
            q.cnt  <= '0;
            q.wptr <= '0;
            q.rptr <= '0;
            q.wcnt <= '0;
            q.rcnt <= '0;
            q.pkts <= '0;
            q.pend <= 1'b0;
            q.gate <= 1'b0;
            q.hold <= 1'b0;
            q.dout <= '0;
            q.dvld <= 1'b0;
            q.derr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    iso_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (push),
        .waddr (q.wptr),
        .wdata (push_data),
        .raddr (q.rptr),
        .rdata (rdata)
    );

    iso_pkt_flags #(.N(DEPTH), .PW(AW)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (switch_req),
        .push   (w_last && !is_tx),
        .bit_in (lk_rx_crc_err),
        .pop    (r_last && !is_tx),
        .head   (flag_head)
    );

    iso_ts_unit #(.TS_W(TS_W)) u_ts (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_tx     (is_tx),
        .trig_n    (ts_trig_n),
        .timer     (cycle_timer),
        .match_in  (ts_match_in),
        .stamp     (ts_value),
        .match_out (ts_match_out)
    );

    assign ready       = is_tx ? (!blocked && q.cnt <= ROOM_C)
                               : (q.pkts != '0 && !q.hold);
    assign lk_tx_valid = is_tx && (q.pkts != '0);
    assign lk_tx_data  = rdata;
    assign lk_tx_last  = lk_tx_valid && (q.rcnt == plen_m1);
    assign dout        = q.dout;
    assign dout_vld    = q.dvld;
    assign crc_err     = q.derr;

    // R2
    room_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tx && !ready && !blocked) |-> (q.cnt >= SLACK_C));

    // R3
    release_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_tx_valid |-> (q.cnt != '0));

    // R5
    turn_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tx && q.pkts != '0) |=> (q.mode == MODE_TX));

    // R7
    drain_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && r_last) |=> !ready);
endmodule

// File: tb/iso_fifo_port_test.sv
module iso_fifo_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_rx = 1'b1;
    logic [15:0] pkt_len = 16'd4;
    logic        byte_en = 1'b0;
    logic [7:0]  din = '0;
    logic        ready;
    logic [7:0]  dout;
    logic        dout_vld, crc_err;
    logic        bus_reset = 1'b0;
    logic        lk_tx_valid;
    logic        lk_tx_ready = 1'b0;
    logic [7:0]  lk_tx_data;
    logic        lk_tx_last;
    logic        lk_rx_valid = 1'b0;
    logic [7:0]  lk_rx_data = '0;
    logic        lk_rx_crc_err = 1'b0;
    logic        ts_trig_n = 1'b1;
    logic [31:0] cycle_timer = '0;
    logic [31:0] ts_value;
    logic        ts_match_in = 1'b0;
    logic        ts_match_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    iso_fifo_port uut (
        .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .pkt_len(pkt_len),
        .byte_en(byte_en), .din(din), .ready(ready), .dout(dout),
        .dout_vld(dout_vld), .crc_err(crc_err), .bus_reset(bus_reset),
        .lk_tx_valid(lk_tx_valid), .lk_tx_ready(lk_tx_ready),
        .lk_tx_data(lk_tx_data), .lk_tx_last(lk_tx_last),
        .lk_rx_valid(lk_rx_valid), .lk_rx_data(lk_rx_data),
        .lk_rx_crc_err(lk_rx_crc_err), .ts_trig_n(ts_trig_n),
        .cycle_timer(cycle_timer), .ts_value(ts_value),
        .ts_match_in(ts_match_in), .ts_match_out(ts_match_out)
    );

    // {rx, crc, 6'b0, length, base}
    localparam logic [23:0] VEC [6] = '{
        24'h00_04_10, 24'h80_05_20, 24'hC0_03_40,
        24'h00_08_80, 24'h00_01_F0, 24'hC0_10_A0
    };

    task automatic step;
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_dir(input logic rx);
        dir_rx = rx;
        step;
        step;
    endtask

    task automatic tx_fill(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            din = 8'(base + i);
            byte_en = 1'b1;
            step;
        end
        byte_en = 1'b0;
    endtask

    task automatic tx_drain(input int n, input logic [7:0] base, input string req);
        lk_tx_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            chk(lk_tx_valid && lk_tx_data == 8'(base + i), req,
                {23'd0, lk_tx_valid, lk_tx_data}, {23'd0, 1'b1, 8'(base + i)});
            chk(lk_tx_last == (i == n - 1), "R3 last", 32'(lk_tx_last), 32'(i == n - 1));
            step;
        end
        lk_tx_ready = 1'b0;
    endtask

    task automatic rx_fill(input int n, input logic [7:0] base, input logic crc);
        for (int i = 0; i < n; i++) begin
            lk_rx_data = 8'(base + i);
            lk_rx_valid = 1'b1;
            lk_rx_crc_err = crc && (i == n - 1);
            step;
        end
        lk_rx_valid = 1'b0;
        lk_rx_crc_err = 1'b0;
    endtask

    task automatic rx_read(input int n, input logic [7:0] base, input logic crc,
                           input string req);
        byte_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            step;
            chk(dout_vld && dout == 8'(base + i), req,
                {23'd0, dout_vld, dout}, {23'd0, 1'b1, 8'(base + i)});
            chk(crc_err == crc, "R9 crc flag", 32'(crc_err), 32'(crc));
        end
        byte_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step;
        rst_n = 1'b1;
        // R1 reset state
        chk(!ready && !lk_tx_valid && !dout_vld && !crc_err && !ts_match_out, "R1 reset",
            {27'd0, ready, lk_tx_valid, dout_vld, crc_err, ts_match_out}, 32'd0);
        step;

        // table walk: R3 transmit, R7/R8/R9 receive
        for (int v = 0; v < 6; v++) begin
            logic       rxm  = VEC[v][23];
            logic       crc  = VEC[v][22];
            int         n    = int'(VEC[v][15:8]);
            logic [7:0] base = VEC[v][7:0];
            pkt_len = 16'(n);
            set_dir(rxm);
            if (!rxm) begin
                tx_fill(n - 1, base);
                chk(!lk_tx_valid, "R3 held before full packet", 32'(lk_tx_valid), 32'd0);
                tx_fill(1, 8'(base + n - 1));
                chk(lk_tx_valid, "R3 released", 32'(lk_tx_valid), 32'd1);
                tx_drain(n, base, "R3 data");
                chk(!lk_tx_valid, "R3 empty after packet", 32'(lk_tx_valid), 32'd0);
            end else begin
                rx_fill(n - 1, base, 1'b0);
                chk(!ready, "R7 ready low on partial", 32'(ready), 32'd0);
                rx_fill(1, 8'(base + n - 1), crc);
                chk(ready, "R7 ready on full packet", 32'(ready), 32'd1);
                rx_read(n, base, crc, "R8 readout");
                step;
                chk(!dout_vld, "R8 no pop", 32'(dout_vld), 32'd0);
                chk(!ready, "R7 empty", 32'(ready), 32'd0);
            end
        end

        // R2 full boundary with slack byte
        pkt_len = 16'd32;
        set_dir(1'b0);
        tx_fill(30, 8'h00);
        chk(ready, "R2 ready at two free", 32'(ready), 32'd1);
        tx_fill(1, 8'd30);
        chk(!ready, "R2 ready low at one free", 32'(ready), 32'd0);
        tx_fill(1, 8'd31);
        chk(lk_tx_valid, "R2 slack byte stored", 32'(lk_tx_valid), 32'd1);
        tx_fill(1, 8'hEE);
        tx_drain(32, 8'h00, "R2 contents");
        chk(!lk_tx_valid && ready, "R2 overflow byte dropped",
            {30'd0, lk_tx_valid, ready}, 32'd1);

        // R6 bus reset at packet boundary
        pkt_len = 16'd4;
        tx_fill(2, 8'h30);
        din = 8'h32; byte_en = 1'b1; bus_reset = 1'b1;
        step;
        bus_reset = 1'b0; din = 8'h33;
        step;
        chk(!ready, "R6 ready low at boundary", 32'(ready), 32'd0);
        din = 8'h99;
        step;
        byte_en = 1'b0;
        chk(!ready, "R6 still gated", 32'(ready), 32'd0);
        tx_drain(4, 8'h30, "R6 packet");
        chk(ready && !lk_tx_valid, "R6 ready back, gated byte dropped",
            {30'd0, ready, lk_tx_valid}, 32'd2);

        // R5 deferred turn-around, R4 partial flush
        tx_fill(4, 8'h50);
        tx_fill(2, 8'h60);
        dir_rx = 1'b1;
        step;
        chk(lk_tx_valid, "R5 turn deferred", 32'(lk_tx_valid), 32'd1);
        tx_drain(4, 8'h50, "R5 packet");
        step;
        chk(!lk_tx_valid && !ready, "R5 now receive and empty",
            {30'd0, lk_tx_valid, ready}, 32'd0);
        rx_fill(4, 8'h70, 1'b0);
        rx_read(4, 8'h70, 1'b0, "R4 no stale tx bytes");
        step;

        // R4 receive packet flushed on turn to transmit
        rx_fill(4, 8'h80, 1'b0);
        chk(ready, "R4 rx packet stored", 32'(ready), 32'd1);
        dir_rx = 1'b0;
        step;
        chk(ready && !lk_tx_valid, "R4 tx empty", {30'd0, ready, lk_tx_valid}, 32'd2);
        dir_rx = 1'b1;
        step;
        chk(!ready, "R4 rx packet flushed", 32'(ready), 32'd0);

        // R7 gap between two stored packets
        pkt_len = 16'd3;
        rx_fill(3, 8'h11, 1'b0);
        rx_fill(3, 8'h21, 1'b1);
        rx_read(3, 8'h11, 1'b0, "R8 first packet");
        chk(!ready, "R7 gap after packet", 32'(ready), 32'd0);
        step;
        chk(ready, "R7 ready again", 32'(ready), 32'd1);
        rx_read(3, 8'h21, 1'b1, "R9 second packet");
        step;
        chk(!ready, "R7 none left", 32'(ready), 32'd0);

        // R11 match forward
        ts_match_in = 1'b1;
        step;
        chk(ts_match_out, "R11 rx forward", 32'(ts_match_out), 32'd1);
        ts_match_in = 1'b0;
        step;
        chk(!ts_match_out, "R11 rx follow low", 32'(ts_match_out), 32'd0);

        // R10 ignored in receive
        cycle_timer = 32'hAAAA_5555;
        ts_trig_n = 1'b0;
        step;
        chk(ts_value == 32'd0, "R10 rx ignores trigger", ts_value, 32'd0);
        ts_trig_n = 1'b1;
        set_dir(1'b0);
        ts_match_in = 1'b1;
        step;
        chk(!ts_match_out, "R11 low in tx", 32'(ts_match_out), 32'd0);
        ts_match_in = 1'b0;
        cycle_timer = 32'h1234_5678;
        ts_trig_n = 1'b0;
        step;
        chk(ts_value == 32'h1234_5678, "R10 latch", ts_value, 32'h1234_5678);
        cycle_timer = 32'h0BAD_F00D;
        step;
        chk(ts_value == 32'h1234_5678, "R10 hold while low", ts_value, 32'h1234_5678);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule